// File: doc/BRIEF.md
# Dual-Modulus Fractional Tick Divider

This block turns a fast input clock into a slow, single-cycle tick enable whose average rate is a fraction of the input rate. It alternates between two integer divide ratios. The first ratio is used for a programmable number of output periods, then the second ratio for its own programmable number of periods, and the pattern repeats. The long-run period is therefore the weighted mean of the two ratios. With ratios 733 and 732 used for 2 and 3 periods, a 24 MHz clock yields close to 32768 ticks per second.

Two 32-bit configuration words set the divider. The first holds the two ratios, a run gate and a mode field. The second holds the two repeat counts. Every count field is stored as its value minus one. A configuration change is applied only at the boundary of a full pattern, so a pattern is never mixed from old and new settings. A select input picks either the divided tick or an externally supplied slow tick as the block's tick output.

Top module: `fd_frac_divider`

## Requirements
- R1: Over one whole pattern, the divider gives exactly M0+M1 ticks in N0*M0 + N1*M1 gated input cycles, so the mean period is that sum divided by M0+M1.
- R2: Field layout, each field holding its count minus one. In `cfg_div`, bits 11:0 hold N0-1 and bits 23:12 hold N1-1. In `cfg_rep`, bits 11:0 hold M0-1 and bits 23:12 hold M1-1.
- R3: In dual mode a pattern is M0 periods of N0 cycles followed by M1 periods of N1 cycles, and then it restarts with N0.
- R4: `div_tick` is high for exactly one cycle, the N-th gated cycle of each period. The next period starts counting in the following gated cycle.
- R5: While `cfg_div` bit 31 is 0, no tick is produced and the cycle, repeat and phase state holds. When the bit returns to 1, counting resumes where it stopped.
- R6: `cfg_div` bits 29:28 equal to 00 select single-ratio mode: every period is N0 cycles and N1 and M1 are ignored. Any nonzero value selects dual mode.
- R7: New configuration words take effect only at the start of a pattern, or in the first gated cycle after reset. A change in mid-pattern leaves the current pattern unchanged.
- R8: With `use_ext` at 1, `tick_out` equals `ext_tick` and divided ticks do not appear on it, while the divider keeps running. With `use_ext` at 0, `tick_out` carries `div_tick`.
- R9: After reset, no tick is pending and the next gated cycle begins a fresh pattern with N0.
- R10: When every stored field is zero, a tick is produced in every gated cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 32 | Ratio word: run gate, mode, N0-1, N1-1 |
| cfg_rep | input | 32 | Repeat word: M0-1, M1-1 |
| ext_tick | input | 1 | External slow tick, one cycle wide, in the clk domain |
| use_ext | input | 1 | 1 selects the external tick for `tick_out` |
| div_tick | output | 1 | Divided tick enable, one cycle wide |
| tick_out | output | 1 | Selected tick |

## Verification
Two small dual patterns are run for several whole patterns. One has N0 greater than N1 and the other the reverse, so a swapped phase order or an off-by-one repeat count moves specific tick cycles. Single-ratio mode uses distinct N1 and M1 values, which would show if they leaked in. A gate pause in mid-pattern, a configuration change in mid-pattern and a reset in mid-run each shift the tick schedule in their own predictable way. The all-zero fields and the 733/732/2/3 setting exercise the smallest and the production ratios.

// File: rtl/fd_pkg.sv
`timescale 1ns/1ps
package fd_pkg;
  localparam int FD_FW    = 12;
  localparam int FD_WW    = 32;
  localparam int MODE_W   = 2;
  // bit positions decoded by software
  localparam int GATE_BIT = 31;
  localparam int MODE_LSB = 28;
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = 12;

  typedef struct packed {
    logic [FD_FW-1:0] n0;
    logic [FD_FW-1:0] n1;
    logic [FD_FW-1:0] m0;
    logic [FD_FW-1:0] m1;
    logic             dual;
  } fd_cfg_t;

  function automatic fd_cfg_t fd_decode(input logic [FD_WW-1:0] wdiv,
                                        input logic [FD_WW-1:0] wrep);
    fd_cfg_t c;
    c.n0   = wdiv[LO_LSB +: FD_FW];
    c.n1   = wdiv[HI_LSB +: FD_FW];
    c.m0   = wrep[LO_LSB +: FD_FW];
    c.m1   = wrep[HI_LSB +: FD_FW];
    c.dual = |wdiv[MODE_LSB +: MODE_W];
    return c;
  endfunction

  function automatic logic [FD_FW-1:0] fd_ratio(input fd_cfg_t c, input logic ph);
    return ph ? c.n1 : c.n0;
  endfunction

  function automatic logic [FD_FW-1:0] fd_reps(input fd_cfg_t c, input logic ph);
    return ph ? c.m1 : c.m0;
  endfunction
endpackage

// File: rtl/fd_cfg_hold.sv
`timescale 1ns/1ps
module fd_cfg_hold
  import fd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    window,
  input  logic    run,
  input  fd_cfg_t live,
  output fd_cfg_t held,
  output fd_cfg_t eff
);
  always_ff @(posedge clk) begin
    if (!rst_n)              held <= '0;
    else if (window && run)  held <= live;
  end

  always_comb eff = window ? live : held;
endmodule

// File: rtl/fd_period_ctr.sv
`timescale 1ns/1ps
module fd_period_ctr #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [FW-1:0] limit,
  output logic [FW-1:0] count,
  output logic          at_zero,
  output logic          period_end
);
  always_comb begin
    at_zero    = (count == '0);
    period_end = run && (count == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (period_end) count <= '0;
    else if (run)        count <= count + 1'b1;
  end
endmodule

// File: rtl/fd_phase_seq.sv
`timescale 1ns/1ps
module fd_phase_seq #(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          dual,
  input  logic [FW-1:0] rep_lim,
  output logic [FW-1:0] rep_cnt,
  output logic          phase,
  output logic          at_start,
  output logic          seq_end
);
  logic rep_last;

  always_comb begin
    rep_last = (rep_cnt == rep_lim);
    at_start = !phase && (rep_cnt == '0);
    seq_end  = step && rep_last && (phase || !dual);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_cnt <= '0;
      phase   <= 1'b0;
    end else if (step) begin
      if (rep_last) begin
        rep_cnt <= '0;
        phase   <= dual ? ~phase : 1'b0;
      end else begin
        rep_cnt <= rep_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fd_frac_divider.sv
`timescale 1ns/1ps
module fd_frac_divider
  import fd_pkg::*;
#(
  parameter int WW = FD_WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] cfg_div,
  input  logic [WW-1:0] cfg_rep,
  input  logic          ext_tick,
  input  logic          use_ext,
  output logic          div_tick,
  output logic          tick_out
);
  localparam int FW = FD_FW;

  // named internal events, used by the bound checker
  logic          gate_on;
  logic          at_sos;
  logic          ctr_zero;
  logic          seq_start;
  logic          seq_end;
  logic          phase;
  logic [FW-1:0] cyc_cnt;
  logic [FW-1:0] rep_cnt;
  logic [FW-1:0] cur_limit;
  logic [FW-1:0] cur_reps;
  fd_cfg_t       live_cfg;
  fd_cfg_t       held_cfg;
  fd_cfg_t       eff_cfg;

  always_comb begin
    gate_on   = cfg_div[GATE_BIT];
    live_cfg  = fd_decode(cfg_div, cfg_rep);
    at_sos    = ctr_zero && seq_start;
    cur_limit = fd_ratio(eff_cfg, phase);
    cur_reps  = fd_reps(eff_cfg, phase);
  end

  fd_cfg_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .window (at_sos),
    .run    (gate_on),
    .live   (live_cfg),
    .held   (held_cfg),
    .eff    (eff_cfg)
  );

  fd_period_ctr #(.FW(FW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (gate_on),
    .limit      (cur_limit),
    .count      (cyc_cnt),
    .at_zero    (ctr_zero),
    .period_end (div_tick)
  );

  fd_phase_seq #(.FW(FW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (div_tick),
    .dual     (eff_cfg.dual),
    .rep_lim  (cur_reps),
    .rep_cnt  (rep_cnt),
    .phase    (phase),
    .at_start (seq_start),
    .seq_end  (seq_end)
  );

  always_comb tick_out = use_ext ? ext_tick : div_tick;
endmodule

// File: rtl/fd_frac_divider_chk.sv
`timescale 1ns/1ps
module fd_frac_divider_chk
  import fd_pkg::*;
#(
  parameter int FW = FD_FW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_on,
  input logic          use_ext,
  input logic          ext_tick,
  input logic          div_tick,
  input logic          tick_out,
  input logic          phase,
  input logic          at_sos,
  input logic [FW-1:0] cyc_cnt,
  input logic [FW-1:0] rep_cnt,
  input logic [FW-1:0] cur_limit,
  input fd_cfg_t       eff_cfg,
  input fd_cfg_t       held_cfg
);
  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |-> !div_tick); // R5
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> ($stable(cyc_cnt) && $stable(rep_cnt) && $stable(phase))); // R5
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (cyc_cnt == '0)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt <= cur_limit); // R4
  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> eff_cfg.dual); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !at_sos |=> $stable(held_cfg)); // R7
  AST_SRC_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext |-> (tick_out == ext_tick)); // R8
endmodule

bind fd_frac_divider fd_frac_divider_chk #(.FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_on   (gate_on),
  .use_ext   (use_ext),
  .ext_tick  (ext_tick),
  .div_tick  (div_tick),
  .tick_out  (tick_out),
  .phase     (phase),
  .at_sos    (at_sos),
  .cyc_cnt   (cyc_cnt),
  .rep_cnt   (rep_cnt),
  .cur_limit (cur_limit),
  .eff_cfg   (eff_cfg),
  .held_cfg  (held_cfg)
);

// File: tb/fd_frac_divider_bench.sv
`timescale 1ns/1ps
module fd_frac_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] w_div = '0;
  logic [31:0] w_rep = '0;
  logic        ext = 1'b0;
  logic        sel_ext = 1'b0;
  logic        div_tick, tick_out;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fd_frac_divider u_fd_frac_divider (
    .clk(clk), .rst_n(rst_n), .cfg_div(w_div), .cfg_rep(w_rep),
    .ext_tick(ext), .use_ext(sel_ext), .div_tick(div_tick), .tick_out(tick_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // word builders: gate in 31, mode in 29:28, counts minus one (R2)
  function automatic logic [31:0] mk_div(input bit g, input logic [1:0] md, input int n0, input int n1);
    logic [11:0] a = 12'(n0 - 1);
    logic [11:0] b = 12'(n1 - 1);
    return {g, 1'b0, md, 4'b0, b, a};
  endfunction
  function automatic logic [31:0] mk_rep(input int m0, input int m1);
    logic [11:0] a = 12'(m0 - 1);
    logic [11:0] b = 12'(m1 - 1);
    return {8'b0, b, a};
  endfunction

  // scoreboard driver: expected tick cycles, with an optional gate pause
  task automatic push_seq(input int start, input int n0, input int n1, input int m0, input int m1,
                          input bit dual, input int count, input int pz_g, input int pz_len,
                          input string tag, output int last);
    int g = -1;
    last = start;
    for (int i = 0; i < count; i++) begin
      int plen = dual ? (m0 + m1) : m0;
      int pos  = i % plen;
      int iv   = (dual && pos >= m0) ? n1 : n0;
      int t;
      g += iv;
      t = start + g + ((g >= pz_g) ? pz_len : 0);
      exp_q.push_back(t);
      tag_q.push_back(tag);
      last = t;
    end
  endtask

  // monitor: compare each tick against the queue
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0] < cyc) begin
      chk(1'b0, {tag_q[0], " missed tick"}, -1, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (tick_out === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected tick", cyc, -1);
      else begin
        chk(exp_q[0] == cyc, tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic at(input int c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; w_div = '0; sel_ext = 1'b0; ext = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    rst_n = 1'b1;
  endtask

  task automatic settle(input string req);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", cyc, -1);
    finish_run();
  end

  initial begin
    int c0, c1, last, l2;

    // R9: reset state and gate-off quiet period (R5)
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(div_tick === 1'b0, "R9 reset div_tick", int'(div_tick), 0);
    chk(tick_out === 1'b0, "R9 reset tick_out", int'(tick_out), 0);
    #1 rst_n = 1'b1;
    w_div = mk_div(1'b0, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    repeat (30) @(negedge clk);
    settle("R5 no tick while gated off");

    // R3/R1: dual 4/3 x 2/3, three patterns
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    push_seq(c0, 4, 3, 2, 3, 1'b1, 15, 1 << 30, 0, "R3", last);
    at(last + 1); w_div[31] = 1'b0;
    chk(last - (c0 - 1) == 3 * (4 * 2 + 3 * 3), "R1 pattern length", last - (c0 - 1), 51);
    settle("R3 drain");

    // R3: reversed ratios 2/5 x 1/2
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 2, 5); w_rep = mk_rep(1, 2);
    push_seq(c0, 2, 5, 1, 2, 1'b1, 9, 1 << 30, 0, "R3 reversed", last);
    at(last + 1); w_div[31] = 1'b0;
    settle("R3 drain reversed");

    // R6: single-ratio mode ignores N1/M1
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b00, 5, 2); w_rep = mk_rep(3, 4);
    push_seq(c0, 5, 2, 3, 4, 1'b0, 8, 1 << 30, 0, "R6", last);
    at(last + 1); w_div[31] = 1'b0;
    settle("R6 drain");

    // R5: gate pause in mid-pattern
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    push_seq(c0, 4, 3, 2, 3, 1'b1, 5, 6, 10, "R5 pause", last);
    at(c0 + 6);  w_div[31] = 1'b0;
    at(c0 + 16); w_div[31] = 1'b1;
    at(last + 1); w_div[31] = 1'b0;
    settle("R5 drain");

    // R7: change in mid-pattern applies at the next pattern
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    push_seq(c0, 4, 3, 2, 3, 1'b1, 5, 1 << 30, 0, "R7 old pattern", last);
    push_seq(c0 + 17, 2, 6, 1, 1, 1'b1, 4, 1 << 30, 0, "R7 new pattern", l2);
    at(c0 + 5);
    w_div = mk_div(1'b1, 2'b01, 2, 6); w_rep = mk_rep(1, 1);
    at(l2 + 1); w_div[31] = 1'b0;
    settle("R7 drain");

    // R8: external source select, divider still running
    do_reset();
    c0 = cyc;
    sel_ext = 1'b1;
    w_div = mk_div(1'b1, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    exp_q.push_back(c0 + 2); tag_q.push_back("R8 ext tick");
    exp_q.push_back(c0 + 9); tag_q.push_back("R8 ext tick");
    at(c0 + 2); ext = 1'b1;
    at(c0 + 3); ext = 1'b0;
    @(negedge clk);
    chk(div_tick === 1'b1, "R8 divider runs under ext select", int'(div_tick), 1);
    at(c0 + 9);  ext = 1'b1;
    at(c0 + 10); ext = 1'b0; w_div[31] = 1'b0;
    at(c0 + 11); sel_ext = 1'b0;
    settle("R8 drain");

    // R10: all fields zero -> tick every gated cycle
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 1, 1); w_rep = mk_rep(1, 1);
    push_seq(c0, 1, 1, 1, 1, 1'b1, 6, 1 << 30, 0, "R10", last);
    at(last + 1); w_div[31] = 1'b0;
    settle("R10 drain");

    // R9: reset in mid-run restarts the pattern
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 4, 3); w_rep = mk_rep(2, 3);
    push_seq(c0, 4, 3, 2, 3, 1'b1, 2, 1 << 30, 0, "R9 before reset", last);
    at(c0 + 9); rst_n = 1'b0;
    at(c0 + 12); rst_n = 1'b1;
    c1 = cyc;
    push_seq(c1, 4, 3, 2, 3, 1'b1, 5, 1 << 30, 0, "R9 after reset", last);
    at(last + 1); w_div[31] = 1'b0;
    settle("R9 drain");

    // R2/R1: production fields 733/732 x 2/3
    do_reset();
    c0 = cyc;
    w_div = mk_div(1'b1, 2'b01, 733, 732); w_rep = mk_rep(2, 3);
    chk(w_div[11:0] == 12'h2DC && w_div[23:12] == 12'h2DB, "R2 stored fields",
        int'(w_div[23:0]), 32'h2DB2DC);
    push_seq(c0, 733, 732, 2, 3, 1'b1, 10, 1 << 30, 0, "R2", last);
    at(last + 1); w_div[31] = 1'b0;
    chk(last - (c0 - 1) == 2 * (733 * 2 + 732 * 3), "R1 production pattern",
        last - (c0 - 1), 7324);
    settle("R2 drain");

    finish_run();
  end
endmodule